// File: doc/BRIEF.md
# Packed Multiply-Add and Absolute-Difference Unit

This block is a single-stage SIMD arithmetic datapath. It takes two 64-bit packed operands, `a_i` and `b_i`, and returns one 64-bit result per clock. It treats the operands either as four 16-bit halfword lanes or as eight 8-bit byte lanes. An operation code selects one of five functions:

- a pairwise halfword multiply-add that gives two 32-bit dot products;
- a per-lane halfword multiply that keeps the high or the low half of each product;
- a four-lane multiply-sum that gives one 64-bit value;
- a byte sum of absolute differences;
- a halfword sum of absolute differences.

A sign control picks two's-complement or unsigned treatment of halfword lanes for the multiplying operations. A half-select picks the product half for the per-lane multiply.

The block has no handshake. The inputs are sampled on every rising clock edge, and the result is held in a register until the next edge. The result register clears under an asynchronous active-low reset.

Top module: `pmad_unit`

## Requirements
- R1: While `rst_ni` is low, `res_o` is 0, and it is cleared as soon as reset is asserted.
- R2: `res_o` takes the result for the inputs present at a rising edge of `clk_i` and holds it until the next rising edge, even if the inputs change in between.
- R3: With `op_i`=0, result bits [31:0] are the sum of the products of halfword lanes 0 and 1 (lane k is bits [16k+15:16k]), truncated to 32 bits. Bits [63:32] are the same for lanes 2 and 3.
- R4: For op codes 0, 1 and 2, `sign_i`=1 treats each halfword lane as two's complement and `sign_i`=0 treats it as unsigned.
- R5: With `op_i`=1, each result lane k is a 16-bit slice of the 32-bit product of lane k of A and B. The slice is bits [15:0] when `hi_i`=0 and bits [31:16] when `hi_i`=1.
- R6: With `op_i`=2, the result is the sum of all four halfword products as a 64-bit value. It is sign-extended when `sign_i`=1 and zero-extended when `sign_i`=0.
- R7: With `op_i`=3, the result is the sum of |A-B| over all eight unsigned byte lanes, zero-extended to 64 bits (at most 11 significant bits).
- R8: With `op_i`=4, the result is the sum of |A-B| over the four unsigned halfword lanes, zero-extended to 64 bits (at most 18 significant bits).
- R9: `sign_i` has no effect for op codes 3 and 4, and `hi_i` has no effect for any op code other than 1.
- R10: Op codes 5, 6 and 7 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 to 4 valid, 5 to 7 give zero) |
| sign_i | input | 1 | 1: halfword lanes are signed, 0: unsigned |
| hi_i | input | 1 | Per-lane multiply: 1 keeps product bits [31:16], 0 keeps [15:0] |
| a_i | input | 64 | Packed operand A |
| b_i | input | 64 | Packed operand B |
| res_o | output | 64 | Registered result |

## Verification
The assertions check the result register against the op code and the operands sampled one edge earlier. For this they need `op_i`, `sign_i`, `a_i` and `b_i` to be stable and known at every rising edge. The bench meets this by changing inputs only on falling edges and by never driving X.

Random operands are mixed with extreme lane values (0x8000, 0xFFFF, 0x0000) and with equal operands. This covers the width bounds of the sums and the zero-difference case that the properties describe.

// File: rtl/pmad_pkg.sv
package pmad_pkg;
  localparam int DATA_W  = 64;
  localparam int HALF_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int HLANES  = DATA_W / HALF_W;
  localparam int BLANES  = DATA_W / BYTE_W;
  localparam int PROD_W  = 2 * HALF_W + 1;
  localparam int MSUM_W  = PROD_W + $clog2(HLANES);
  localparam int PAIR_W  = 2 * HALF_W;

  typedef enum logic [2:0] {
    OP_MADD = 3'd0,
    OP_MUL  = 3'd1,
    OP_MSUM = 3'd2,
    OP_SADB = 3'd3,
    OP_SADH = 3'd4
  } op_e;
endpackage

// File: rtl/pmad_mul_lanes.sv
module pmad_mul_lanes #(
  parameter int DW     = 64,
  parameter int LW     = 16,
  parameter int NL     = DW / LW,
  parameter int PW     = 2 * LW + 1
) (
  input  logic [DW-1:0]        a_i,
  input  logic [DW-1:0]        b_i,
  input  logic                 sign_i,
  output logic [NL-1:0][PW-1:0] prod_o
);
  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic signed [LW:0]     ea, eb;
    logic signed [2*LW+1:0] full;
    always_comb begin
      ea   = {sign_i & a_i[k*LW+LW-1], a_i[k*LW +: LW]};
      eb   = {sign_i & b_i[k*LW+LW-1], b_i[k*LW +: LW]};
      full = ea * eb;
      prod_o[k] = full[PW-1:0];
    end
  end
endmodule

// File: rtl/pmad_sad.sv
module pmad_sad #(
  parameter int DW    = 64,
  parameter int LW    = 8,
  parameter int NL    = DW / LW,
  parameter int SUM_W = LW + $clog2(NL)
) (
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [NL-1:0][LW-1:0] diff;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [LW-1:0] x, y;
    always_comb begin
      x = a_i[k*LW +: LW];
      y = b_i[k*LW +: LW];
      diff[k] = (x >= y) ? (x - y) : (y - x);
    end
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NL; k++) sum_o = sum_o + SUM_W'(diff[k]);
  end
endmodule

// File: rtl/pmad_unit.sv
module pmad_unit
  import pmad_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic              sign_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int SADB_W = BYTE_W + $clog2(BLANES);
  localparam int SADH_W = HALF_W + $clog2(HLANES);

  logic [HLANES-1:0][PROD_W-1:0] prod;
  logic [SADB_W-1:0]             sadb;
  logic [SADH_W-1:0]             sadh;
  logic [MSUM_W-1:0]             msum;
  logic [DATA_W-1:0]             madd_r, mul_r, msum_r, nxt;

  pmad_mul_lanes #(.DW(DATA_W), .LW(HALF_W), .NL(HLANES), .PW(PROD_W)) u_mul (
    .a_i(a_i), .b_i(b_i), .sign_i(sign_i), .prod_o(prod)
  );

  pmad_sad #(.DW(DATA_W), .LW(BYTE_W), .NL(BLANES), .SUM_W(SADB_W)) u_sadb (
    .a_i(a_i), .b_i(b_i), .sum_o(sadb)
  );

  pmad_sad #(.DW(DATA_W), .LW(HALF_W), .NL(HLANES), .SUM_W(SADH_W)) u_sadh (
    .a_i(a_i), .b_i(b_i), .sum_o(sadh)
  );

  // pair sums wrap at 32 bits
  always_comb begin
    for (int p = 0; p < HLANES / 2; p++)
      madd_r[p*PAIR_W +: PAIR_W] = prod[2*p][PAIR_W-1:0] + prod[2*p+1][PAIR_W-1:0];
  end

  always_comb begin
    for (int k = 0; k < HLANES; k++)
      mul_r[k*HALF_W +: HALF_W] = hi_i ? prod[k][PAIR_W-1:HALF_W] : prod[k][HALF_W-1:0];
  end

  // products are already sign-correct 33-bit values; unsigned ones have a 0 top bit
  always_comb begin
    msum = '0;
    for (int k = 0; k < HLANES; k++)
      msum = msum + {{(MSUM_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    msum_r = {{(DATA_W-MSUM_W){msum[MSUM_W-1]}}, msum};
  end

  always_comb begin
    unique case (op_i)
      OP_MADD: nxt = madd_r;
      OP_MUL:  nxt = mul_r;
      OP_MSUM: nxt = msum_r;
      OP_SADB: nxt = DATA_W'(sadb);
      OP_SADH: nxt = DATA_W'(sadh);
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= nxt;
  end
endmodule

// File: rtl/pmad_chk.sv
module pmad_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  op_i,
  input logic        sign_i,
  input logic [63:0] a_i,
  input logic [63:0] b_i,
  input logic [63:0] res_o
);
  // R1: result held at zero across a reset cycle
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> (res_o == 64'd0));

  assert_sadb_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3) |=> (res_o[63:11] == '0));

  assert_sadh_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4) |=> (res_o[63:18] == '0));

  assert_sad_equal_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 3'd3 || op_i == 3'd4) && a_i == b_i) |=> (res_o == 64'd0));

  assert_msum_zext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && !sign_i) |=> (res_o[63:34] == '0));

  assert_msum_sext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && sign_i) |=> ($countones(res_o[63:34]) == 0 || $countones(res_o[63:34]) == 30));

  assert_bad_op_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 3'd4) |=> (res_o == 64'd0));

  assert_zero_operand_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= 3'd2 && a_i == 64'd0) |=> (res_o == 64'd0));
endmodule

bind pmad_unit pmad_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .sign_i(sign_i),
  .a_i(a_i), .b_i(b_i), .res_o(res_o)
);

// File: tb/tb_pmad_unit.sv
`timescale 1ns/1ps
module tb_pmad_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic        sign_i = 1'b0;
  logic        hi_i = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] res_o;

  int checks = 0;
  int errors = 0;

  pmad_unit dut (.*);

  always #4 clk_i = ~clk_i;

  function automatic longint lane16(logic [63:0] v, int k, logic s);
    logic [15:0] x = v[16*k +: 16];
    return s ? longint'($signed(x)) : longint'(x);
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic s, logic h,
                                        logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    logic [63:0] t;
    longint acc = 0;
    case (op)
      3'd0: for (int p = 0; p < 2; p++) begin
        t = lane16(a, 2*p, s) * lane16(b, 2*p, s) + lane16(a, 2*p+1, s) * lane16(b, 2*p+1, s);
        r[32*p +: 32] = t[31:0];
      end
      3'd1: for (int k = 0; k < 4; k++) begin
        t = lane16(a, k, s) * lane16(b, k, s);
        r[16*k +: 16] = h ? t[31:16] : t[15:0];
      end
      3'd2: begin
        for (int k = 0; k < 4; k++) acc += lane16(a, k, s) * lane16(b, k, s);
        r = acc;
      end
      3'd3: begin
        for (int k = 0; k < 8; k++) begin
          longint d = longint'(a[8*k +: 8]) - longint'(b[8*k +: 8]);
          acc += (d < 0) ? -d : d;
        end
        r = acc;
      end
      3'd4: begin
        for (int k = 0; k < 4; k++) begin
          longint d = lane16(a, k, 1'b0) - lane16(b, k, 1'b0);
          acc += (d < 0) ? -d : d;
        end
        r = acc;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op, logic s);
    case (op)
      3'd0: return s ? "R3/R4" : "R3";
      3'd1: return s ? "R5/R4" : "R5";
      3'd2: return s ? "R6/R4" : "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at falling edge, check at next falling edge
  task automatic run(logic [2:0] op, logic s, logic h, logic [63:0] a, logic [63:0] b);
    op_i = op; sign_i = s; hi_i = h; a_i = a; b_i = b;
    @(negedge clk_i);
    check(tag_of(op, s), res_o, model(op, s, h, a, b));
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 5))
      0: return 64'h8000_8000_8000_8000;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7FFF_0000_8001_FFFF;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] hold;
    void'($urandom(32'd20240611));
    op_i = 3'd3; a_i = 64'hFF; b_i = 64'h0;
    repeat (3) @(negedge clk_i);
    check("R1", res_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed corners
    run(3'd0, 1'b1, 1'b0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
    run(3'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run(3'd1, 1'b1, 1'b1, 64'hFFFF_8000_7FFF_0003, 64'h0002_8000_7FFF_FFFF);
    run(3'd1, 1'b0, 1'b1, 64'hFFFF_8000_7FFF_0003, 64'h0002_8000_7FFF_FFFF);
    run(3'd1, 1'b1, 1'b0, 64'hFFFF_8000_7FFF_0003, 64'h0002_8000_7FFF_FFFF);
    run(3'd2, 1'b1, 1'b0, 64'h8000_8000_8000_8000, 64'h7FFF_7FFF_7FFF_7FFF);
    run(3'd2, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run(3'd3, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    run(3'd4, 1'b0, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    run(3'd4, 1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
    run(3'd7, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);

    // R9: flipping sign_i / hi_i on unaffected ops keeps the result
    for (int i = 0; i < 20; i++) begin
      logic [63:0] a = pick(), b = pick();
      logic [2:0] op = (i % 2) ? 3'd3 : 3'd4;
      op_i = op; sign_i = 1'b0; hi_i = 1'b0; a_i = a; b_i = b;
      @(negedge clk_i);
      hold = res_o;
      sign_i = 1'b1; hi_i = 1'b1;
      @(negedge clk_i);
      check("R9", res_o, hold);
      op_i = 3'd2; sign_i = i[0]; hi_i = 1'b0;
      @(negedge clk_i);
      hold = res_o;
      hi_i = 1'b1;
      @(negedge clk_i);
      check("R9", res_o, hold);
    end

    // R2: result holds when inputs change before the next edge
    run(3'd4, 1'b0, 1'b0, 64'h0000_0000_0000_0010, 64'h0);
    hold = res_o;
    op_i = 3'd3; a_i = 64'hFFFF; b_i = 64'h0;
    #2;
    check("R2", res_o, hold);
    @(negedge clk_i);
    check("R2", res_o, 64'd510);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a = pick();
      logic [63:0] b = ($urandom_range(0, 9) == 0) ? a : pick();
      run(3'($urandom_range(0, 7)), 1'($urandom()), 1'($urandom()), a, b);
    end

    // R1: asynchronous clear mid-run
    run(3'd3, 1'b0, 1'b0, 64'hFF, 64'h0);
    #1 rst_ni = 1'b0;
    #1 check("R1", res_o, 64'd0);
    @(negedge clk_i);
    check("R1", res_o, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule